// File: doc/BRIEF.md
# Converter Control and Successive-Approximation Sequencer

This block is the digital side of a four-input analog-to-digital converter in a small 8-bit controller. Software reaches it over a byte-wide register bus with address, write data, write strobe and read data. It owns a control register, a clock-select register and read-only result bytes. From these it drives the analog multiplexer select, the analog/digital mode of the port pins and the power enable of the analog front end. It also steps a trial code into an external DAC and samples an external comparator bit.

Software starts a conversion with two writes. The first sets the start bit, which raises the busy flag. The second clears the start bit, which launches the binary search. The search spends one converter-clock period on each result bit, beginning with the most significant. When the last bit is decided, the result bytes are loaded, the busy flag drops and a one-cycle interrupt request is sent if the interrupt is enabled. The resolution is a parameter of 8 or 9 bits. In the 9-bit build the result is split over two bytes.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Control bits 2:0 choose the input channel. The code drives `chan_sel` directly, except that codes 4 to 7 drive channel 0. A control read returns the code exactly as written.
- R2: Control bits 5:3 hold a pin-mode code c. Pin i of `pin_analog` is 1 (analog: digital driver and pull-up off) exactly when i < c, so codes 4 to 7 make all four pins analog. `conv_power` is 1 whenever any pin is analog.
- R3: Writing control bit 7 from 0 to 1 sets the busy flag, which reads back as control bit 6. Writes to bit 6 itself are ignored.
- R4: A conversion starts only on a 1-to-0 write of bit 7 that follows a 0-to-1 write of bit 7. A 0 written while bit 7 is already 0 starts nothing. A held 1 starts nothing.
- R5: On completion, the busy flag clears and the result bytes load. `irq` is high for one cycle if `irq_en` was high at that moment. With `irq_en` low, no pulse is sent.
- R6: The map is: 0x20 low result byte, 0x21 high result byte, 0x22 control, 0x23 clock select. Other addresses read 0. Reads are registered: the data appears one clock after the address. Writes to 0x20 and 0x21 are ignored.
- R7: Clock-select bits 1:0 = s give a converter clock of the system clock divided by 2^s. `irq` rises RES·2^s clocks after the launching write. Clock-select bit 7 is reserved: it is not stored, reads 0 and has no effect. Bits 6:2 also read 0.
- R8: The search sets each trial bit, MSB first. It keeps the bit when `cmp_in` is 1 (input at or above `dac_code`). The final result therefore equals the input level.
- R9: A new 0-to-1 write of bit 7 during a conversion aborts it. The result bytes stay unchanged, no interrupt is sent and the busy flag stays set. A later 1-to-0 write starts a fresh conversion.
- R10: The 9-bit result puts bits 8:1 in byte 0x21 and bit 0 in bit 7 of byte 0x20. The other bits of 0x20 read 0.
- R11: After reset, all registers and the read data are 0, `irq` is 0, channel 0 is selected and every pin is digital.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| cmp_in | input | 1 | Comparator: 1 when input ≥ `dac_code` |
| dac_code | output | RES | Trial code for the DAC |
| chan_sel | output | 2 | Analog multiplexer select |
| pin_analog | output | 4 | Per-pin analog mode |
| conv_power | output | 1 | Analog front-end power enable |
| irq_en | input | 1 | Converter interrupt enable |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Each result has a fixed due time:
- Read data follows the address by one clock edge.
- Pin mode and channel select follow a control write by one edge.
- The busy flag sets on the edge of the 0-to-1 write.
- The interrupt pulse, busy clear and result load all land exactly RES·2^s edges after the edge that takes the launching write.

The bench samples at falling edges. It counts falling edges from the launching write until `irq` appears, and compares that count with RES·2^s. It reads results only after that point. Negative checks (aborts, disabled interrupts, lone writes of 0) wait well past the longest possible conversion before they look at `irq` and the result bytes.

// File: rtl/adc_pkg.sv
package adc_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] ADR_RLO  = 8'h20;
  localparam logic [AW-1:0] ADR_RHI  = 8'h21;
  localparam logic [AW-1:0] ADR_CTRL = 8'h22;
  localparam logic [AW-1:0] ADR_CSR  = 8'h23;
  // control field positions (software-visible)
  localparam int CB_START = 7;
  localparam int CB_BUSY  = 6;
  localparam int SELW     = 2;
endpackage

// File: rtl/adc_clk_en.sv
module adc_clk_en #(
  parameter int SELW = 2,
  localparam int CW = (1 << SELW) - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            run,
  input  logic [SELW-1:0] sel,
  output logic            tick
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = CW'((1 << sel) - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run)       cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
  end

  // R7: with a divider above 1, enables never come on consecutive cycles
  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && sel != '0 && $stable(sel) && !restart) |=> !tick);
endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int RES = 9,
  localparam int IW = $clog2(RES)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           abort,
  input  logic           tick,
  input  logic           cmp_in,
  output logic           busy,
  output logic           done,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] result
);
  localparam logic [IW-1:0] MSB = IW'(RES - 1);
  logic [IW-1:0]  idx;
  logic [RES-1:0] kept;

  always_comb begin
    kept      = trial;
    kept[idx] = cmp_in;
  end

  assign done = busy && tick && (idx == '0) && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      trial  <= '0;
      result <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      trial <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      idx   <= MSB;
      trial <= RES'(1) << MSB;
    end else if (busy && tick) begin
      if (idx == '0) begin
        busy   <= 1'b0;
        trial  <= kept;
        result <= kept;
      end else begin
        trial <= kept | (RES'(1) << (idx - 1'b1));
        idx   <= idx - 1'b1;
      end
    end
  end

  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
  assert_done_ends_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  assert_go_msb_trial_R8: assert property (@(posedge clk) disable iff (rst)
    (go && !abort) |=> (busy && trial[RES-1] && $countones(trial) == 1));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES  = 9,
  parameter int NCH  = 4,
  parameter int NPIN = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [adc_pkg::AW-1:0] bus_addr,
  input  logic [7:0]             bus_wdata,
  input  logic                   bus_we,
  output logic [7:0]             bus_rdata,
  input  logic                   cmp_in,
  output logic [RES-1:0]         dac_code,
  output logic [CHW-1:0]         chan_sel,
  output logic [NPIN-1:0]        pin_analog,
  output logic                   conv_power,
  input  logic                   irq_en,
  output logic                   irq
);
  import adc_pkg::*;

  logic [2:0]      chan_r, pcfg_r;
  logic            start_r, busy_r, armed_r;
  logic [SELW-1:0] sel_r;
  logic            ctrl_wr, start_rise, start_fall;
  logic            tick, sar_busy, conv_done;
  logic [RES-1:0]  res_w;
  logic [7:0]      lo_byte, hi_byte, rd_mux;

  assign ctrl_wr    = bus_we && (bus_addr == ADR_CTRL);
  assign start_rise = ctrl_wr &&  bus_wdata[CB_START] && !start_r;
  assign start_fall = ctrl_wr && !bus_wdata[CB_START] &&  start_r && armed_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_r  <= '0;
      pcfg_r  <= '0;
      start_r <= 1'b0;
      busy_r  <= 1'b0;
      armed_r <= 1'b0;
      sel_r   <= '0;
      irq     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        chan_r  <= bus_wdata[2:0];
        pcfg_r  <= bus_wdata[5:3];
        start_r <= bus_wdata[CB_START];
      end
      if (bus_we && bus_addr == ADR_CSR) sel_r <= bus_wdata[SELW-1:0];
      if (start_rise)      armed_r <= 1'b1;
      else if (start_fall) armed_r <= 1'b0;
      if (start_rise)     busy_r <= 1'b1;
      else if (conv_done) busy_r <= 1'b0;
      irq <= conv_done && irq_en;
    end
  end

  adc_clk_en #(.SELW(SELW)) u_clk_en (
    .clk(clk), .rst(rst), .restart(start_fall), .run(sar_busy),
    .sel(sel_r), .tick(tick)
  );

  adc_sar #(.RES(RES)) u_sar (
    .clk(clk), .rst(rst), .go(start_fall), .abort(start_rise), .tick(tick),
    .cmp_in(cmp_in), .busy(sar_busy), .done(conv_done), .trial(dac_code),
    .result(res_w)
  );

  assign chan_sel = (32'(chan_r) >= NCH) ? '0 : CHW'(chan_r);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pin_analog[i] = (32'(pcfg_r) > i);
  end
  assign conv_power = |pin_analog;

  if (RES > 8) begin : g_split
    assign hi_byte = res_w[RES-1 -: 8];
    assign lo_byte = {res_w[0], 7'b0};
  end else begin : g_single
    assign hi_byte = 8'(res_w);
    assign lo_byte = 8'h00;
  end

  always_comb begin
    unique case (bus_addr)
      ADR_RLO:  rd_mux = lo_byte;
      ADR_RHI:  rd_mux = hi_byte;
      ADR_CTRL: rd_mux = {start_r, busy_r, pcfg_r, chan_r};
      ADR_CSR:  rd_mux = 8'(sel_r);
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assert_busy_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    start_rise |=> busy_r);
  assert_busy_clear_R5: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !busy_r);
  assert_irq_source_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(conv_done && irq_en));
  assert_lone_fall_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !bus_wdata[CB_START] && !start_r && !sar_busy) |=> !sar_busy);
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int RES = 9;
  logic       clk = 0, rst = 1;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic       bus_we = 0, cmp_in, conv_power, irq_en = 1, irq;
  logic [RES-1:0] dac_code;
  logic [1:0] chan_sel;
  logic [3:0] pin_analog;
  logic [8:0] vin = 0;
  int total = 0, bad = 0, irq_cnt = 0;

  always #10 clk = ~clk;
  assign cmp_in = (vin >= dac_code);
  always @(posedge clk) if (irq) irq_cnt++;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .dac_code(dac_code), .chan_sel(chan_sel), .pin_analog(pin_analog),
    .conv_power(conv_power), .irq_en(irq_en), .irq(irq)
  );

  // {sel[15:14], chan[13:11], 2'b0, vin[8:0]}
  localparam logic [15:0] VECS [6] = '{16'h0000, 16'h49FF, 16'h9100,
                                       16'hD8AB, 16'h1155, 16'h88FE};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a;
    @(posedge clk); @(negedge clk); d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic convert(input logic [7:0] csr, input logic [5:0] low6,
                         input logic [8:0] v, input int exp_cyc);
    logic [7:0] d; int n, base;
    wr(8'h23, csr); vin = v; base = irq_cnt;
    wr(8'h22, {2'b10, low6});
    rd(8'h22, d); check(d[6] == 1'b1, "R3 busy set on rise", d[6], 1);
    wr(8'h22, {2'b00, low6});
    wait_irq(n);
    check(n == exp_cyc, "R7 completion latency", n, exp_cyc);
    rd(8'h22, d); check(d[6] == 1'b0, "R5 busy cleared", d[6], 0);
    rd(8'h21, d); check(d == v[8:1], "R8 high byte", d, v[8:1]);
    rd(8'h20, d); check(d == {v[0], 7'b0}, "R10 low byte", d, {v[0], 7'b0});
    check(irq_cnt == base + 1, "R5 one irq pulse", irq_cnt - base, 1);
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d; int n, base;
    idle(3); rst = 0;
    // R11 reset state
    foreach (d[k]) ; // no-op
    for (int a = 8'h20; a <= 8'h23; a++) begin
      rd(8'(a), d); check(d == 0, "R11 reset register", d, 0);
    end
    check(irq == 0 && chan_sel == 0 && pin_analog == 0 && !conv_power,
          "R11 reset outputs", {irq, chan_sel, pin_analog}, 0);

    // vector table: conversions across dividers, channels, levels
    for (int i = 0; i < 6; i++) begin
      logic [1:0] s; logic [2:0] c;
      s = VECS[i][15:14]; c = VECS[i][13:11];
      convert({6'b0, s}, {3'b000, c}, VECS[i][8:0], RES << s);
      check(chan_sel == c[1:0], "R1 channel select", chan_sel, c);
    end

    // R1 reserved channel code
    wr(8'h22, 8'h05);
    check(chan_sel == 0, "R1 reserved code to ch0", chan_sel, 0);
    rd(8'h22, d); check(d[2:0] == 3'd5, "R1 raw readback", d[2:0], 5);

    // R2 pin modes
    wr(8'h22, 8'h00); check(pin_analog == 4'b0000 && !conv_power, "R2 code0", pin_analog, 0);
    wr(8'h22, 8'h10); check(pin_analog == 4'b0011 && conv_power, "R2 code2", pin_analog, 3);
    wr(8'h22, 8'h20); check(pin_analog == 4'b1111, "R2 code4", pin_analog, 15);
    wr(8'h22, 8'h38); check(pin_analog == 4'b1111 && conv_power, "R2 code7", pin_analog, 15);

    // R3 bit 6 write ignored
    wr(8'h22, 8'h40); rd(8'h22, d);
    check(d[6] == 0, "R3 busy not writable", d[6], 0);

    // R4 lone zero write and held one start nothing
    base = irq_cnt; wr(8'h22, 8'h00); idle(100);
    check(irq_cnt == base, "R4 no start without rise", irq_cnt - base, 0);
    wr(8'h23, 8'h00); vin = 9'h033;
    wr(8'h22, 8'h80); idle(100);
    check(irq_cnt == base, "R4 held start idle", irq_cnt - base, 0);
    rd(8'h22, d); check(d[6] == 1, "R4 busy held", d[6], 1);
    wr(8'h22, 8'h00); wait_irq(n);
    check(n == RES, "R4 fall launches", n, RES);

    // R7 reserved test bit in clock select
    wr(8'h23, 8'h81); rd(8'h23, d);
    check(d == 8'h01, "R7 bit7 not stored", d, 1);
    convert(8'h81, 6'h00, 9'h1A5, RES * 2);

    // R6 result read-only, unmapped reads zero
    wr(8'h21, 8'h00); wr(8'h20, 8'hFF);
    rd(8'h21, d); check(d == 8'hD2, "R6 high read-only", d, 8'hD2);
    rd(8'h20, d); check(d == 8'h80, "R6 low read-only", d, 8'h80);
    rd(8'h24, d); check(d == 0, "R6 unmapped", d, 0);

    // R5 interrupt masked
    irq_en = 0; base = irq_cnt; vin = 9'h0C3;
    wr(8'h23, 8'h00); wr(8'h22, 8'h80); wr(8'h22, 8'h00); idle(40);
    check(irq_cnt == base, "R5 masked irq", irq_cnt - base, 0);
    rd(8'h22, d); check(d[6] == 0, "R5 busy cleared masked", d[6], 0);
    rd(8'h21, d); check(d == 8'h61, "R5 result loaded masked", d, 8'h61);
    irq_en = 1;

    // R9 abort and restart
    base = irq_cnt; vin = 9'h040;
    wr(8'h23, 8'h03); wr(8'h22, 8'h80); wr(8'h22, 8'h00); idle(20);
    vin = 9'h077; wr(8'h22, 8'h80); idle(100);
    check(irq_cnt == base, "R9 abort no irq", irq_cnt - base, 0);
    rd(8'h21, d); check(d == 8'h61, "R9 result kept", d, 8'h61);
    rd(8'h22, d); check(d[6] == 1, "R9 busy stays", d[6], 1);
    wr(8'h22, 8'h00); wait_irq(n);
    check(n == RES * 8, "R9 restart latency", n, RES * 8);
    rd(8'h21, d); check(d == 8'h3B, "R9 new result", d, 8'h3B);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule